// File: doc/BRIEF.md
# Linked-List DMA Channel Sequencer

This block is the control sequencer for a single DMA channel that takes its work from a chain of descriptors in memory. Software loads the address of the first descriptor and then sets a run bit. The channel reads the four-word descriptor, which holds the address of the next descriptor, a source address, a target address and a command word. From the command word it decides how to move the data. It either moves words freely or waits for a peripheral request before each word, and it counts the length down to zero. It then either fetches the next descriptor in the chain or stops.

All bus traffic goes through one word-wide memory port with a request/acknowledge handshake. Each data word is read from the source and then written to the target. A status view gives software the run bit, a stopped flag, an error flag and a start interrupt that is raised by each completed descriptor fetch. Software clears that interrupt by writing a one to it.

Top module: `dma_desc_seq`

## Requirements
- R1: After reset the run bit, stopped flag, error flag and start interrupt all read 0, and the memory port makes no request.
- R2: Loading a descriptor address while the run bit is clear causes no memory request. Once the run bit is set, the next cycle but one issues the first descriptor read at that address, with bits 1:0 of the address treated as 0.
- R3: A descriptor fetch makes exactly four reads, at base, base+4, base+8 and base+12, before any data access. The words read are, in order, the next pointer, the source address, the target address and the command. Command bit 31 is the source flow bit, bit 30 is the target flow bit, and bits 15:0 are the byte length. Bit 0 of the next pointer is the stop bit.
- R4: With both flow bits clear, the channel moves length/4 words without a handshake. Each word is a read from the source followed by a write to the target, and both addresses step by 4 after each word.
- R5: With exactly one flow bit set, the channel moves no word until periph_req is high. A periph_req that is high for one cycle lets exactly one word through.
- R6: When the last word of a descriptor has moved, the channel enters the stopped state if the stop bit is set. If the stop bit is clear, it fetches the descriptor at the next pointer.
- R7: Each completed descriptor fetch sets the start interrupt. A register write with irq_clr=1 clears it, and a write with irq_clr=0 leaves it set.
- R8: The stopped flag reads 1 while the channel is stopped. Writing the run bit to 1 in that state does not restart the channel: run and stopped then both read 1 and no memory request is made.
- R9: If both flow bits are set, the channel raises the error flag and moves no data. The flag stays set while run is 1. Clearing run returns the channel to the reset state with all flags 0.
- R10: Clearing the run bit during a word transfer lets that word finish its read and its write, and the channel then enters the stopped state.
- R11: A descriptor with length 0 moves no data and then follows the stop-bit rule of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| csr_wr | input | 1 | Write strobe for the control register |
| csr_run | input | 1 | Run bit value written by csr_wr |
| csr_irq_clr | input | 1 | Write 1 with csr_wr to clear the start interrupt |
| ptr_wr | input | 1 | Load strobe for the first descriptor address |
| ptr_wdata | input | 32 | Descriptor address, bit 0 = stop |
| run_o | output | 1 | Current run bit |
| stopped_o | output | 1 | Channel is in the stopped state |
| start_irq_o | output | 1 | Descriptor-fetch interrupt flag |
| error_o | output | 1 | Conflicting flow bits detected |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes this cycle |
| periph_req | input | 1 | Peripheral request for flow-controlled transfers |

## Verification
The data-moving function is exercised with five command patterns: free transfer, source-paced, target-paced, both flow bits set, and zero length. Comparing the read and write counts against the target memory contents separates a correct copy from three kinds of failure: a copy that should have been refused, a transfer off by one word, and a fetch of the wrong size. A two-descriptor chain with its stop bit clear on the first link, and the fetch addresses sampled cycle by cycle, separates following the next pointer from stopping early. Directed runs that hold periph_req low and then pulse it, stall the acknowledge while run is cleared, and write run into a stopped or failed channel separate handshake pacing, the finish-the-word rule and the sticky flags.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [3:0] {
    ST_UNINIT,
    ST_VALID,
    ST_FETCH,
    ST_DECODE,
    ST_WAIT,
    ST_RD,
    ST_WR,
    ST_STOP,
    ST_ERR
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_DESC,
    OP_RD,
    OP_WR
  } mem_op_e;

  localparam int unsigned FLOW_SRC_BIT = 31;
  localparam int unsigned FLOW_TGT_BIT = 30;
  localparam int unsigned LAST_DESC_IDX = 3;

endpackage

// File: rtl/dma_seq_csr.sv
module dma_seq_csr (
  input  logic clk,
  input  logic rst_n,
  input  logic csr_wr,
  input  logic csr_run,
  input  logic csr_irq_clr,
  input  logic fetch_done,
  output logic run,
  output logic start_flag
);

  logic run_d, flag_d;

  always_comb begin
    run_d  = run;
    flag_d = start_flag;
    if (csr_wr) run_d = csr_run;
    // a new fetch completion wins over a clear in the same cycle
    if (fetch_done) flag_d = 1'b1;
    else if (csr_wr && csr_irq_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      start_flag <= 1'b0;
    end else begin
      run        <= run_d;
      start_flag <= flag_d;
    end
  end

  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> start_flag);

  p_irq_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_flag && !fetch_done && !(csr_wr && csr_irq_clr)) |=> start_flag);

endmodule

// File: rtl/dma_seq_path.sv
module dma_seq_path
  import dma_seq_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load,
  input  logic [WORD_W-1:0] ptr_wdata,
  input  mem_op_e           mem_op,
  input  logic [1:0]        fetch_idx,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              stop_bit,
  output logic              flow_src,
  output logic              flow_tgt,
  output logic              words_zero,
  output logic              words_last
);

  localparam int unsigned CNT_W = LEN_W - 2;

  logic [WORD_W-1:0] next_ptr, ptr_stage, src_addr, tgt_addr, data_buf;
  logic [CNT_W-1:0]  words_left;
  logic [1:0]        flow_q;

  logic desc_ack, rd_ack, wr_ack;

  assign desc_ack = (mem_op == OP_DESC) && mem_ack;
  assign rd_ack   = (mem_op == OP_RD)   && mem_ack;
  assign wr_ack   = (mem_op == OP_WR)   && mem_ack;

  // next pointer: a software load, or committed from staging after the last word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_ptr  <= '0;
      ptr_stage <= '0;
    end else begin
      if (ptr_load) next_ptr <= ptr_wdata;
      else if (desc_ack && fetch_idx == 2'(LAST_DESC_IDX)) next_ptr <= ptr_stage;
      if (desc_ack && fetch_idx == 2'd0) ptr_stage <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr <= '0;
    end else if (desc_ack && fetch_idx == 2'd1) begin
      src_addr <= mem_rdata;
    end else if (rd_ack) begin
      src_addr <= src_addr + WORD_W'(4);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_addr <= '0;
    end else if (desc_ack && fetch_idx == 2'd2) begin
      tgt_addr <= mem_rdata;
    end else if (wr_ack) begin
      tgt_addr <= tgt_addr + WORD_W'(4);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_left <= '0;
      flow_q     <= '0;
    end else if (desc_ack && fetch_idx == 2'(LAST_DESC_IDX)) begin
      words_left <= mem_rdata[LEN_W-1:2];
      flow_q     <= {mem_rdata[FLOW_SRC_BIT], mem_rdata[FLOW_TGT_BIT]};
    end else if (wr_ack) begin
      words_left <= words_left - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_buf <= '0;
    else if (rd_ack) data_buf <= mem_rdata;
  end

  always_comb begin
    unique case (mem_op)
      OP_DESC: mem_addr = {next_ptr[WORD_W-1:2], 2'b00}
                          + {{(WORD_W-4){1'b0}}, fetch_idx, 2'b00};
      OP_RD:   mem_addr = src_addr;
      OP_WR:   mem_addr = tgt_addr;
      default: mem_addr = '0;
    endcase
  end

  assign mem_wdata  = data_buf;
  assign stop_bit   = next_ptr[0];
  assign flow_src   = flow_q[1];
  assign flow_tgt   = flow_q[0];
  assign words_zero = (words_left == '0);
  assign words_last = (words_left == CNT_W'(1));

  p_src_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> src_addr == $past(src_addr) + WORD_W'(4));

  p_tgt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> tgt_addr == $past(tgt_addr) + WORD_W'(4));

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       ptr_wr,
  input  logic       periph_req,
  input  logic       mem_ack,
  input  logic       stop_bit,
  input  logic       flow_src,
  input  logic       flow_tgt,
  input  logic       words_zero,
  input  logic       words_last,
  output seq_state_e state,
  output mem_op_e    mem_op,
  output logic [1:0] fetch_idx,
  output logic       ptr_load,
  output logic       fetch_done
);

  seq_state_e state_q, state_d, end_state, data_state;
  logic [1:0] idx_q;

  assign end_state  = stop_bit ? ST_STOP : ST_FETCH;
  assign data_state = (flow_src ^ flow_tgt) ? ST_WAIT : ST_RD;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_UNINIT: if (ptr_wr) state_d = ST_VALID;
      ST_VALID:  if (run) state_d = ST_FETCH;
      ST_FETCH:  if (mem_ack && idx_q == 2'(LAST_DESC_IDX)) state_d = ST_DECODE;
      ST_DECODE: begin
        if (!run)                       state_d = ST_STOP;
        else if (flow_src && flow_tgt)  state_d = ST_ERR;
        else if (words_zero)            state_d = end_state;
        else                            state_d = data_state;
      end
      ST_WAIT: begin
        if (!run)            state_d = ST_STOP;
        else if (periph_req) state_d = ST_RD;
      end
      ST_RD: if (mem_ack) state_d = ST_WR;
      ST_WR: begin
        if (mem_ack) begin
          if (!run)            state_d = ST_STOP;
          else if (words_last) state_d = end_state;
          else                 state_d = data_state;
        end
      end
      ST_STOP: if (ptr_wr) state_d = ST_VALID;
      ST_ERR:  if (!run) state_d = ST_UNINIT;
      default: state_d = ST_UNINIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_UNINIT;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (state_q == ST_FETCH && mem_ack) idx_q <= idx_q + 2'd1;
  end

  always_comb begin
    unique case (state_q)
      ST_FETCH: mem_op = OP_DESC;
      ST_RD:    mem_op = OP_RD;
      ST_WR:    mem_op = OP_WR;
      default:  mem_op = OP_NONE;
    endcase
  end

  assign state      = state_q;
  assign fetch_idx  = idx_q;
  assign ptr_load   = ptr_wr && (state_q == ST_UNINIT || state_q == ST_VALID
                                 || state_q == ST_STOP);
  assign fetch_done = (state_q == ST_FETCH) && mem_ack
                      && (idx_q == 2'(LAST_DESC_IDX));

  p_run_starts_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VALID && run) |=> state_q == ST_FETCH);

  p_fetch_then_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> state_q == ST_DECODE);

  p_wait_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !periph_req) |=> (state_q == ST_WAIT || state_q == ST_STOP));

  p_stop_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && !ptr_wr) |=> state_q == ST_STOP);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ERR && run) |=> state_q == ST_ERR);

  p_word_finishes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD && mem_ack) |=> state_q == ST_WR);

endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic              csr_run,
  input  logic              csr_irq_clr,
  input  logic              ptr_wr,
  input  logic [WORD_W-1:0] ptr_wdata,
  output logic              run_o,
  output logic              stopped_o,
  output logic              start_irq_o,
  output logic              error_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              periph_req
);

  logic [1:0] rst_sync;
  logic       rst_core_n;

  // assert asynchronously, release on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  seq_state_e state;
  mem_op_e    mem_op;
  logic [1:0] fetch_idx;
  logic       ptr_load, fetch_done, run;
  logic       stop_bit, flow_src, flow_tgt, words_zero, words_last;

  dma_seq_csr i_csr (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .csr_wr      (csr_wr),
    .csr_run     (csr_run),
    .csr_irq_clr (csr_irq_clr),
    .fetch_done  (fetch_done),
    .run         (run),
    .start_flag  (start_irq_o)
  );

  dma_seq_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .run        (run),
    .ptr_wr     (ptr_wr),
    .periph_req (periph_req),
    .mem_ack    (mem_ack),
    .stop_bit   (stop_bit),
    .flow_src   (flow_src),
    .flow_tgt   (flow_tgt),
    .words_zero (words_zero),
    .words_last (words_last),
    .state      (state),
    .mem_op     (mem_op),
    .fetch_idx  (fetch_idx),
    .ptr_load   (ptr_load),
    .fetch_done (fetch_done)
  );

  dma_seq_path #(
    .WORD_W (WORD_W),
    .LEN_W  (LEN_W)
  ) i_path (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ptr_load   (ptr_load),
    .ptr_wdata  (ptr_wdata),
    .mem_op     (mem_op),
    .fetch_idx  (fetch_idx),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .stop_bit   (stop_bit),
    .flow_src   (flow_src),
    .flow_tgt   (flow_tgt),
    .words_zero (words_zero),
    .words_last (words_last)
  );

  assign run_o     = run;
  assign stopped_o = (state == ST_STOP);
  assign error_o   = (state == ST_ERR);
  assign mem_req   = (mem_op != OP_NONE);
  assign mem_we    = (mem_op == OP_WR);

endmodule

// File: tb/test_dma_desc_seq.sv
module test_dma_desc_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0, csr_run = 1'b0, csr_irq_clr = 1'b0;
  logic        ptr_wr = 1'b0;
  logic [31:0] ptr_wdata = '0;
  logic        run_o, stopped_o, start_irq_o, error_o;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        periph_req = 1'b0;
  logic        ack_en = 1'b1;

  logic        tb_we = 1'b0;
  logic [31:0] tb_addr = '0, tb_data = '0;
  logic [31:0] mem [0:63];
  logic        cnt_clr = 1'b0;
  int          rd_cnt, wr_cnt;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dma_desc_seq i_dma_desc_seq (
    .clk, .rst_n, .csr_wr, .csr_run, .csr_irq_clr, .ptr_wr, .ptr_wdata,
    .run_o, .stopped_o, .start_irq_o, .error_o,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack, .periph_req
  );

  assign mem_ack   = mem_req & ack_en;
  assign mem_rdata = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr[7:2]] <= tb_data;
    else if (mem_req && mem_we && mem_ack) mem[mem_addr[7:2]] <= mem_wdata;
  end

  always @(posedge clk) begin
    if (cnt_clr) begin
      rd_cnt <= 0;
      wr_cnt <= 0;
    end else if (mem_req && mem_ack) begin
      if (mem_we) wr_cnt <= wr_cnt + 1;
      else        rd_cnt <= rd_cnt + 1;
    end
  end

  // {src flow, tgt flow, expect error, word count}
  localparam logic [6:0] VEC [5] = '{
    7'b000_0011,
    7'b100_0010,
    7'b010_0001,
    7'b111_0010,
    7'b000_0000
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mem_put(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = a; tb_data = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic csr_write(input logic r, input logic c);
    @(negedge clk);
    csr_wr = 1'b1; csr_run = r; csr_irq_clr = c;
    @(negedge clk);
    csr_wr = 1'b0; csr_irq_clr = 1'b0;
  endtask

  task automatic ptr_write(input logic [31:0] p);
    @(negedge clk);
    ptr_wr = 1'b1; ptr_wdata = p;
    @(negedge clk);
    ptr_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cnt_clr = 1'b1; periph_req = 1'b0; ack_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; cnt_clr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (stopped_o || error_o) break;
    end
  endtask

  task automatic put_desc(input logic [31:0] base, input logic [31:0] nxt,
                          input logic [31:0] src, input logic [31:0] tgt,
                          input logic fs, input logic ft, input logic [3:0] n);
    mem_put(base, nxt);
    mem_put(base + 4, src);
    mem_put(base + 8, tgt);
    mem_put(base + 12, {fs, ft, 14'd0, 10'd0, n, 2'b00});
  endtask

  task automatic run_tests();
    // reset state
    do_reset();
    chk("R1 run", {31'd0, run_o}, 32'd0);
    chk("R1 stopped", {31'd0, stopped_o}, 32'd0);
    chk("R1 error", {31'd0, error_o}, 32'd0);
    chk("R1 irq", {31'd0, start_irq_o}, 32'd0);
    repeat (5) @(negedge clk);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);

    // table of command patterns
    for (int v = 0; v < 5; v++) begin
      logic fs, ft, er;
      logic [3:0] n;
      string tag;
      {fs, ft, er, n} = VEC[v];
      tag = er ? "R9" : (n == 0) ? "R11" : (fs | ft) ? "R5" : "R4";
      do_reset();
      put_desc(32'h0, 32'h1, 32'h40, 32'h80, fs, ft, n);
      for (int k = 0; k < 4; k++) begin
        mem_put(32'h40 + 4 * k, 32'hA000_0000 + 32'(v * 16 + k));
        mem_put(32'h80 + 4 * k, 32'h0);
      end
      periph_req = 1'b1;
      ptr_write(32'h0);
      csr_write(1'b1, 1'b0);
      wait_idle();
      periph_req = 1'b0;
      chk({tag, " stopped (R6)"}, {31'd0, stopped_o}, {31'd0, ~er});
      chk({tag, " error"}, {31'd0, error_o}, {31'd0, er});
      chk({tag, " start irq R7"}, {31'd0, start_irq_o}, 32'd1);
      chk({tag, " reads R3"}, 32'(rd_cnt), er ? 32'd4 : 32'd4 + 32'(n));
      chk({tag, " writes"}, 32'(wr_cnt), er ? 32'd0 : 32'(n));
      for (int k = 0; k < 4; k++)
        chk({tag, " target word"}, mem[32 + k],
            (k < n && !er) ? 32'hA000_0000 + 32'(v * 16 + k) : 32'h0);
    end

    // R2, R3, R6: two-link chain, fetch addresses sampled cycle by cycle
    do_reset();
    put_desc(32'h00, 32'h10, 32'h40, 32'h80, 1'b0, 1'b0, 4'd2);
    put_desc(32'h10, 32'h01, 32'h50, 32'hA0, 1'b0, 1'b0, 4'd1);
    mem_put(32'h40, 32'h1111_0000);
    mem_put(32'h44, 32'h1111_0001);
    mem_put(32'h50, 32'h2222_0000);
    mem_put(32'h80, 32'h0);
    mem_put(32'h84, 32'h0);
    mem_put(32'hA0, 32'h0);
    ptr_write(32'h2);
    repeat (4) @(negedge clk);
    chk("R2 no request before run", {31'd0, mem_req}, 32'd0);
    csr_write(1'b1, 1'b0);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk("R3 fetch request", {31'd0, mem_req & ~mem_we}, 32'd1);
      chk("R2/R3 fetch address", mem_addr, 32'(4 * k));
      @(negedge clk);
    end
    wait_idle();
    chk("R6 chain link one w0", mem[32], 32'h1111_0000);
    chk("R6 chain link one w1", mem[33], 32'h1111_0001);
    chk("R6 chain link two", mem[40], 32'h2222_0000);
    chk("R6 chain reads", 32'(rd_cnt), 32'd11);
    chk("R6 chain stopped", {31'd0, stopped_o}, 32'd1);

    // R7 / R8: write-one-to-clear, run into a stopped channel
    csr_write(1'b1, 1'b0);
    chk("R7 zero write keeps irq", {31'd0, start_irq_o}, 32'd1);
    repeat (6) @(negedge clk);
    chk("R8 run and stopped", {30'd0, run_o, stopped_o}, 32'd3);
    chk("R8 no restart", {31'd0, mem_req}, 32'd0);
    chk("R8 no new reads", 32'(rd_cnt), 32'd11);
    csr_write(1'b0, 1'b1);
    chk("R7 one write clears irq", {31'd0, start_irq_o}, 32'd0);

    // R5: paced transfer waits for the request
    do_reset();
    put_desc(32'h0, 32'h1, 32'h40, 32'h80, 1'b1, 1'b0, 4'd3);
    ptr_write(32'h0);
    csr_write(1'b1, 1'b0);
    repeat (20) @(negedge clk);
    chk("R5 no word without request", 32'(wr_cnt), 32'd0);
    chk("R5 fetch done", 32'(rd_cnt), 32'd4);
    periph_req = 1'b1;
    @(negedge clk);
    periph_req = 1'b0;
    repeat (10) @(negedge clk);
    chk("R5 one pulse one word", 32'(wr_cnt), 32'd1);
    periph_req = 1'b1;
    wait_idle();
    periph_req = 1'b0;
    chk("R5 all words", 32'(wr_cnt), 32'd3);

    // R10: run cleared while a source read is stalled
    do_reset();
    put_desc(32'h0, 32'h1, 32'h40, 32'h80, 1'b0, 1'b0, 4'd4);
    mem_put(32'h40, 32'h5555_0000);
    mem_put(32'h80, 32'h0);
    mem_put(32'h84, 32'h0);
    ptr_write(32'h0);
    csr_write(1'b1, 1'b0);
    for (int i = 0; i < 50; i++) begin
      if (mem_req && !mem_we && mem_addr == 32'h40) break;
      @(negedge clk);
    end
    ack_en = 1'b0;
    csr_write(1'b0, 1'b0);
    ack_en = 1'b1;
    wait_idle();
    chk("R10 one word written", 32'(wr_cnt), 32'd1);
    chk("R10 word data", mem[32], 32'h5555_0000);
    chk("R10 next word untouched", mem[33], 32'h0);
    chk("R10 stopped, run clear", {30'd0, run_o, stopped_o}, 32'd1);

    // R9: error holds until run is cleared
    do_reset();
    put_desc(32'h0, 32'h1, 32'h40, 32'h80, 1'b1, 1'b1, 4'd1);
    ptr_write(32'h0);
    csr_write(1'b1, 1'b0);
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R9 error held", {31'd0, error_o}, 32'd1);
    chk("R9 no writes", 32'(wr_cnt), 32'd0);
    csr_write(1'b0, 1'b0);
    @(negedge clk);
    chk("R9 cleared flags", {29'd0, error_o, stopped_o, run_o}, 32'd0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule